// File: doc/BRIEF.md
# Keyboard Controller Host Command Engine

This block is the host-side register and command engine of a legacy PC keyboard and pointing-device controller. The host sees two byte addresses behind one chip select. Address 0 is the data port and address 1 is the command/status port. The engine holds three registers: the mode byte, the output-port byte and a self-test flag. It decodes one-byte controller commands and emits replies toward the output-buffer logic. It forwards host data bytes to the keyboard or auxiliary device, and it drives the A20 gate and a system reset request.

Several commands are two-phase. A command write arms a pending code, and that code decides what the next data-port write does: load the mode byte, load the output port, inject a reply byte, or forward the byte to the auxiliary device. Any command whose upper nibble is all ones is a pulse request. Bit 0 of that command decides whether a CPU reset pulse is produced. The output-buffer logic reports whether keyboard or auxiliary bytes are waiting. From those two inputs and the mode byte, the engine forms the buffer-full status bits and the two interrupt lines.

Top module: `kbc_cmd_engine`

## Requirements
- R1: After reset the mode byte is 0x03, status is 0x18, output port is 0xCF, a20 is 1, xlate_en is 0, bad_cmd is 0 and both interrupts are low.
- R2: Command 0x20 makes reply_valid high for one cycle, in the cycle after the write, with reply_aux=0 and reply_data equal to the mode byte.
- R3: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 arm the next data write. That write respectively loads the mode byte, loads the output port, replies the byte with reply_aux=0, replies it with reply_aux=1, or forwards it on aux_dev_data. Every data write clears the pending code.
- R4: A data write with nothing armed pulses kbd_dev_valid for one cycle, with kbd_dev_data equal to the written byte.
- R5: A command with upper nibble 0xF and bit 0 clear produces a one-cycle sys_reset_req. With bit 0 set it has no effect.
- R6: Command 0xAA sets status bit 2 and replies 0x55. Commands 0xA9 and 0xAB reply 0x00. Command 0xC0 replies 0x80. Command 0xD0 replies the output port, with bit 4 and bit 5 reflecting the live buffer-full state.
- R7: Commands 0xA7 and 0xA8 set and clear mode bit 5. Commands 0xAD and 0xAE set and clear mode bit 4.
- R8: Command 0xDF sets a20 and output-port bit 1. Command 0xDD clears both.
- R9: An output-port load drives a20 from value bit 1. If value bit 0 is 0, the load produces a one-cycle sys_reset_req.
- R10: A mode load sets the mode byte to the written value, and xlate_en follows its bit 6.
- R11: Status bit 0 is set while either device has a byte waiting. When only the auxiliary device has a byte waiting, status bit 5 is set and irq_aux follows mode bit 1. When the keyboard has a byte waiting, it takes priority, and irq_kbd is set when mode bit 0 is set and mode bit 4 is clear.
- R12: An unknown command code changes no register, produces no reply and sets the sticky bad_cmd flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select for a host access |
| wr | input | 1 | Write strobe, qualified by cs |
| addr | input | 1 | 0 = data port, 1 = command/status port |
| wdata | input | 8 | Host write byte |
| kbd_pending | input | 1 | Keyboard byte waiting in output buffer |
| aux_pending | input | 1 | Auxiliary byte waiting in output buffer |
| reply_valid | output | 1 | One-cycle reply push strobe |
| reply_data | output | 8 | Reply byte |
| reply_aux | output | 1 | Reply goes to auxiliary buffer |
| kbd_dev_valid | output | 1 | Forward strobe to keyboard device |
| kbd_dev_data | output | 8 | Byte for keyboard device |
| aux_dev_valid | output | 1 | Forward strobe to auxiliary device |
| aux_dev_data | output | 8 | Byte for auxiliary device |
| sys_reset_req | output | 1 | One-cycle system reset request |
| a20 | output | 1 | A20 gate |
| xlate_en | output | 1 | Scan-code translation enable |
| irq_kbd | output | 1 | Keyboard interrupt level |
| irq_aux | output | 1 | Auxiliary interrupt level |
| status | output | 8 | Status byte |
| mode | output | 8 | Mode byte |
| outport | output | 8 | Output-port view |
| bad_cmd | output | 1 | Sticky unsupported-command flag |

## Verification
A wrong pending code shows on the data write that follows. The byte then appears on the wrong strobe, or is lost, one cycle after that write. The bench therefore follows every armed write with a second, plain data write and expects a keyboard forward. A stale mode or output-port register shows on the next 0x20 or 0xD0 reply one cycle later, and it shows at once on the interrupt and status lines when the pending inputs are toggled.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

  localparam int BYTE_W = 8;

  // mode byte fields
  localparam int MB_KBD_IRQ = 0;
  localparam int MB_AUX_IRQ = 1;
  localparam int MB_KBD_OFF = 4;
  localparam int MB_AUX_OFF = 5;
  localparam int MB_XLATE   = 6;

  // status byte fields
  localparam int SB_ANY_FULL = 0;
  localparam int SB_SELFTEST = 2;
  localparam int SB_CMD_LAST = 3;
  localparam int SB_UNLOCKED = 4;
  localparam int SB_AUX_FULL = 5;

  // output port fields
  localparam int OB_RUN     = 0;
  localparam int OB_A20     = 1;
  localparam int OB_FULL    = 4;
  localparam int OB_AUXFULL = 5;

  typedef enum logic [2:0] {
    PW_NONE, PW_MODE, PW_OUTP, PW_KBUF, PW_ABUF, PW_AUXDEV
  } pend_e;

  typedef struct packed {
    logic              reply_en;
    logic [BYTE_W-1:0] reply_val;
    logic              reply_mode;
    logic              reply_outp;
    logic              arm_en;
    pend_e             arm_code;
    logic [BYTE_W-1:0] mode_set;
    logic [BYTE_W-1:0] mode_clr;
    logic              selftest;
    logic              a20_on;
    logic              a20_off;
    logic              cpu_reset;
    logic              unknown;
  } cmd_act_t;

  // pulse family: upper nibble all ones, bit 0 selects reset or nothing
  function automatic logic [BYTE_W-1:0] fold_pulse(input logic [BYTE_W-1:0] c);
    if (c[7:4] == 4'hF) return c[0] ? 8'hFF : 8'hFE;
    return c;
  endfunction

  function automatic cmd_act_t decode_cmd(input logic [BYTE_W-1:0] raw,
                                          input logic [BYTE_W-1:0] st_reply,
                                          input logic [BYTE_W-1:0] inport_val);
    cmd_act_t a;
    logic [BYTE_W-1:0] c;
    a = '0;
    a.arm_code = PW_NONE;
    c = fold_pulse(raw);
    case (c)
      8'h20: a.reply_mode = 1'b1;
      8'h60: begin a.arm_en = 1'b1; a.arm_code = PW_MODE;   end
      8'hD1: begin a.arm_en = 1'b1; a.arm_code = PW_OUTP;   end
      8'hD2: begin a.arm_en = 1'b1; a.arm_code = PW_KBUF;   end
      8'hD3: begin a.arm_en = 1'b1; a.arm_code = PW_ABUF;   end
      8'hD4: begin a.arm_en = 1'b1; a.arm_code = PW_AUXDEV; end
      8'hA7: a.mode_set[MB_AUX_OFF] = 1'b1;
      8'hA8: a.mode_clr[MB_AUX_OFF] = 1'b1;
      8'hAD: a.mode_set[MB_KBD_OFF] = 1'b1;
      8'hAE: a.mode_clr[MB_KBD_OFF] = 1'b1;
      8'hAA: begin a.selftest = 1'b1; a.reply_val = st_reply; end
      8'hA9, 8'hAB: a.reply_val = 8'h00;
      8'hC0: a.reply_val = inport_val;
      8'hD0: a.reply_outp = 1'b1;
      8'hDF: a.a20_on  = 1'b1;
      8'hDD: a.a20_off = 1'b1;
      8'hFE: a.cpu_reset = 1'b1;
      8'hFF: ;
      default: a.unknown = 1'b1;
    endcase
    a.reply_en = a.reply_mode | a.reply_outp
               | (c == 8'hAA) | (c == 8'hA9) | (c == 8'hAB) | (c == 8'hC0);
    return a;
  endfunction

  function automatic logic [BYTE_W-1:0] make_status(input logic any_full,
                                                    input logic aux_only,
                                                    input logic selftest);
    logic [BYTE_W-1:0] s;
    s = '0;
    s[SB_ANY_FULL] = any_full;
    s[SB_SELFTEST] = selftest;
    s[SB_CMD_LAST] = 1'b1;
    s[SB_UNLOCKED] = 1'b1;
    s[SB_AUX_FULL] = aux_only;
    return s;
  endfunction

  function automatic logic [BYTE_W-1:0] make_outport(input logic [BYTE_W-1:0] stored,
                                                     input logic any_full,
                                                     input logic aux_only);
    logic [BYTE_W-1:0] o;
    o = stored;
    o[OB_FULL]    = any_full;
    o[OB_AUXFULL] = aux_only;
    return o;
  endfunction

endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
  import kbc_pkg::*;
#(
  parameter logic [7:0] ST_REPLY   = 8'h55,
  parameter logic [7:0] INPORT_VAL = 8'h80
) (
  input  logic [BYTE_W-1:0] cmd_byte,
  output cmd_act_t          act
);
  always_comb act = decode_cmd(cmd_byte, ST_REPLY, INPORT_VAL);
endmodule

// File: rtl/kbc_irq_status.sv
module kbc_irq_status
  import kbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kbd_pending,
  input  logic              aux_pending,
  input  logic [BYTE_W-1:0] mode_q,
  input  logic [BYTE_W-1:0] outp_q,
  input  logic              selftest_q,
  output logic [BYTE_W-1:0] status_view,
  output logic [BYTE_W-1:0] outp_view,
  output logic              irq_kbd,
  output logic              irq_aux
);
  logic any_full, aux_only;

  // keyboard bytes win over auxiliary bytes
  assign any_full = kbd_pending | aux_pending;
  assign aux_only = aux_pending & ~kbd_pending;

  assign status_view = make_status(any_full, aux_only, selftest_q);
  assign outp_view   = make_outport(outp_q, any_full, aux_only);
  assign irq_aux = aux_only & mode_q[MB_AUX_IRQ];
  assign irq_kbd = kbd_pending & mode_q[MB_KBD_IRQ] & ~mode_q[MB_KBD_OFF];

  assert_irq_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_kbd && irq_aux));

  assert_aux_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_aux |-> status_view[SB_AUX_FULL] && status_view[SB_ANY_FULL]);
endmodule

// File: rtl/kbc_reg_file.sv
module kbc_reg_file
  import kbc_pkg::*;
#(
  parameter logic [7:0] MODE_INIT = 8'h03,
  parameter logic [7:0] OUTP_INIT = 8'hCF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              dat_wr,
  input  logic [BYTE_W-1:0] wdata,
  input  cmd_act_t          act,
  input  logic [BYTE_W-1:0] outp_view,
  output logic [BYTE_W-1:0] mode_q,
  output logic [BYTE_W-1:0] outp_q,
  output logic              selftest_q,
  output logic              bad_q,
  output logic              reply_v,
  output logic [BYTE_W-1:0] reply_d,
  output logic              reply_aux,
  output logic              kdev_v,
  output logic [BYTE_W-1:0] kdev_d,
  output logic              adev_v,
  output logic [BYTE_W-1:0] adev_d,
  output logic              rst_req
);
  pend_e pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MODE_INIT;
      outp_q     <= OUTP_INIT;
      selftest_q <= 1'b0;
      bad_q      <= 1'b0;
      pend_q     <= PW_NONE;
      reply_v    <= 1'b0;
      reply_d    <= '0;
      reply_aux  <= 1'b0;
      kdev_v     <= 1'b0;
      kdev_d     <= '0;
      adev_v     <= 1'b0;
      adev_d     <= '0;
      rst_req    <= 1'b0;
    end else begin
      reply_v <= 1'b0;
      kdev_v  <= 1'b0;
      adev_v  <= 1'b0;
      rst_req <= 1'b0;
      if (cmd_wr) begin
        if (act.arm_en) pend_q <= act.arm_code;
        mode_q <= (mode_q | act.mode_set) & ~act.mode_clr;
        if (act.selftest)  selftest_q <= 1'b1;
        if (act.a20_on)    outp_q[OB_A20] <= 1'b1;
        if (act.a20_off)   outp_q[OB_A20] <= 1'b0;
        if (act.cpu_reset) rst_req <= 1'b1;
        if (act.unknown)   bad_q <= 1'b1;
        if (act.reply_en) begin
          reply_v   <= 1'b1;
          reply_aux <= 1'b0;
          reply_d   <= act.reply_mode ? mode_q :
                       act.reply_outp ? outp_view : act.reply_val;
        end
      end
      if (dat_wr) begin
        pend_q <= PW_NONE;
        case (pend_q)
          PW_MODE: mode_q <= wdata;
          PW_OUTP: begin
            outp_q  <= wdata;
            rst_req <= ~wdata[OB_RUN];
          end
          PW_KBUF: begin
            reply_v <= 1'b1; reply_aux <= 1'b0; reply_d <= wdata;
          end
          PW_ABUF: begin
            reply_v <= 1'b1; reply_aux <= 1'b1; reply_d <= wdata;
          end
          PW_AUXDEV: begin
            adev_v <= 1'b1; adev_d <= wdata;
          end
          default: begin
            kdev_v <= 1'b1; kdev_d <= wdata;
          end
        endcase
      end
    end
  end

  assert_pend_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr |=> pend_q == PW_NONE);

  assert_mode_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && pend_q == PW_MODE) |=> mode_q == $past(wdata) && mode_q[MB_XLATE] == $past(wdata[MB_XLATE]));

  assert_reset_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  assert_a20_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && act.a20_on) |=> outp_q[OB_A20]);

  assert_unknown_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && act.unknown) |=> !reply_v && bad_q && $stable(mode_q));
endmodule

// File: rtl/kbc_cmd_engine.sv
module kbc_cmd_engine
  import kbc_pkg::*;
#(
  parameter logic [7:0] MODE_INIT  = 8'h03,
  parameter logic [7:0] OUTP_INIT  = 8'hCF,
  parameter logic [7:0] ST_REPLY   = 8'h55,
  parameter logic [7:0] INPORT_VAL = 8'h80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       wr,
  input  logic       addr,
  input  logic [7:0] wdata,
  input  logic       kbd_pending,
  input  logic       aux_pending,
  output logic       reply_valid,
  output logic [7:0] reply_data,
  output logic       reply_aux,
  output logic       kbd_dev_valid,
  output logic [7:0] kbd_dev_data,
  output logic       aux_dev_valid,
  output logic [7:0] aux_dev_data,
  output logic       sys_reset_req,
  output logic       a20,
  output logic       xlate_en,
  output logic       irq_kbd,
  output logic       irq_aux,
  output logic [7:0] status,
  output logic [7:0] mode,
  output logic [7:0] outport,
  output logic       bad_cmd
);
  logic              cmd_wr, dat_wr;
  cmd_act_t          act;
  logic [BYTE_W-1:0] mode_q, outp_q, outp_view;
  logic              selftest_q;

  assign cmd_wr = cs & wr & addr;
  assign dat_wr = cs & wr & ~addr;

  kbc_cmd_decode #(.ST_REPLY(ST_REPLY), .INPORT_VAL(INPORT_VAL)) u_dec (
    .cmd_byte (wdata),
    .act      (act)
  );

  kbc_reg_file #(.MODE_INIT(MODE_INIT), .OUTP_INIT(OUTP_INIT)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (cmd_wr),
    .dat_wr     (dat_wr),
    .wdata      (wdata),
    .act        (act),
    .outp_view  (outp_view),
    .mode_q     (mode_q),
    .outp_q     (outp_q),
    .selftest_q (selftest_q),
    .bad_q      (bad_cmd),
    .reply_v    (reply_valid),
    .reply_d    (reply_data),
    .reply_aux  (reply_aux),
    .kdev_v     (kbd_dev_valid),
    .kdev_d     (kbd_dev_data),
    .adev_v     (aux_dev_valid),
    .adev_d     (aux_dev_data),
    .rst_req    (sys_reset_req)
  );

  kbc_irq_status u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .kbd_pending (kbd_pending),
    .aux_pending (aux_pending),
    .mode_q      (mode_q),
    .outp_q      (outp_q),
    .selftest_q  (selftest_q),
    .status_view (status),
    .outp_view   (outp_view),
    .irq_kbd     (irq_kbd),
    .irq_aux     (irq_aux)
  );

  assign mode     = mode_q;
  assign outport  = outp_view;
  assign a20      = outp_q[OB_A20];
  assign xlate_en = mode_q[MB_XLATE];
endmodule

// File: tb/kbc_cmd_engine_tb.sv
`timescale 1ns/1ps
module kbc_cmd_engine_tb;
  logic clk = 0, rst_n = 0, cs = 0, wr = 0, addr = 0;
  logic [7:0] wdata = 0;
  logic kbd_pending = 0, aux_pending = 0;
  logic reply_valid, reply_aux, kbd_dev_valid, aux_dev_valid, sys_reset_req;
  logic [7:0] reply_data, kbd_dev_data, aux_dev_data, status, mode, outport;
  logic a20, xlate_en, irq_kbd, irq_aux, bad_cmd;

  int total = 0, bad = 0;
  bit done = 0;
  // expected event kinds: 0 kbd reply, 1 aux reply, 2 kbd device, 3 aux device, 4 reset
  int        ek[$];
  logic [7:0] ed[$];
  string     et[$];

  always #2 clk = ~clk;

  kbc_cmd_engine u_dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_ev(int k, logic [7:0] d, string tag);
    ek.push_back(k); ed.push_back(d); et.push_back(tag);
  endtask

  task automatic seen(int k, logic [7:0] d);
    total++;
    if (ek.size() == 0) begin
      bad++;
      $display("FAIL unexpected event: actual kind=%0d data=%h expected none", k, d);
    end else begin
      int xk; logic [7:0] xd; string xt;
      xk = ek.pop_front(); xd = ed.pop_front(); xt = et.pop_front();
      if (xk != k || xd !== d) begin
        bad++;
        $display("FAIL %s: actual kind=%0d data=%h expected kind=%0d data=%h", xt, k, d, xk, xd);
      end
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (reply_valid)   seen(reply_aux ? 1 : 0, reply_data);
      if (kbd_dev_valid) seen(2, kbd_dev_data);
      if (aux_dev_valid) seen(3, aux_dev_data);
      if (sys_reset_req) seen(4, 8'h00);
    end
  end

  task automatic put(logic a, logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", mode, 8'h03);
    chk("R1 status", status, 8'h18);
    chk("R1 outport", outport, 8'hCF);
    chk("R1 a20/xlate/bad/irq", {a20, xlate_en, bad_cmd, irq_kbd, irq_aux}, 5'b10000);

    // R2
    expect_ev(0, 8'h03, "R2 read mode"); put(1, 8'h20);
    // R6
    expect_ev(0, 8'h55, "R6 self test"); put(1, 8'hAA);
    chk("R6 status selftest", status, 8'h1C);
    expect_ev(0, 8'h00, "R6 aux test"); put(1, 8'hA9);
    expect_ev(0, 8'h00, "R6 kbd test"); put(1, 8'hAB);
    expect_ev(0, 8'h80, "R6 input port"); put(1, 8'hC0);
    expect_ev(0, 8'hCF, "R6 output port"); put(1, 8'hD0);
    // R7
    put(1, 8'hA7); chk("R7 aux off", mode, 8'h23);
    put(1, 8'hA8); chk("R7 aux on", mode, 8'h03);
    put(1, 8'hAD); chk("R7 kbd off", mode, 8'h13);
    put(1, 8'hAE); chk("R7 kbd on", mode, 8'h03);
    // R8
    put(1, 8'hDD); chk("R8 a20 off", {a20, outport}, {1'b0, 8'hCD});
    put(1, 8'hDF); chk("R8 a20 on", {a20, outport}, {1'b1, 8'hCF});
    // R5
    put(1, 8'hF1); put(1, 8'hFF);
    chk("R5 no-op leaves state", {mode, outport, bad_cmd}, {8'h03, 8'hCF, 1'b0});
    expect_ev(4, 8'h00, "R5 pulse FE"); put(1, 8'hFE);
    expect_ev(4, 8'h00, "R5 pulse F6"); put(1, 8'hF6);
    // R4
    expect_ev(2, 8'h5A, "R4 forward"); put(0, 8'h5A);
    // R3 R10 mode load, then pending cleared
    put(1, 8'h60); put(0, 8'h47);
    chk("R10 mode load", {mode, xlate_en}, {8'h47, 1'b1});
    expect_ev(2, 8'h11, "R3 pending cleared"); put(0, 8'h11);
    put(1, 8'h60); put(0, 8'h03);
    chk("R10 xlate off", {mode, xlate_en}, {8'h03, 1'b0});
    // R3 buffers and aux device
    put(1, 8'hD2); expect_ev(0, 8'h9C, "R3 kbd inject"); put(0, 8'h9C);
    put(1, 8'hD3); expect_ev(1, 8'h3E, "R3 aux inject"); put(0, 8'h3E);
    put(1, 8'hD4); expect_ev(3, 8'hE8, "R3 aux device"); put(0, 8'hE8);
    expect_ev(2, 8'h22, "R3 cleared after aux"); put(0, 8'h22);
    // R9 output port loads
    put(1, 8'hD1); put(0, 8'hCD);
    chk("R9 outport load", {a20, outport}, {1'b0, 8'hCD});
    put(1, 8'hD1); expect_ev(4, 8'h00, "R9 reset bit"); put(0, 8'hCE);
    chk("R9 outport reset load", {a20, outport}, {1'b1, 8'hCE});
    put(1, 8'hD1); put(0, 8'hCF);
    // R12
    put(1, 8'h12);
    chk("R12 unknown", {bad_cmd, mode, outport}, {1'b1, 8'h03, 8'hCF});
    put(1, 8'hAE);
    chk("R12 sticky", bad_cmd, 1'b1);
    // R11
    @(negedge clk); kbd_pending = 1; @(negedge clk);
    chk("R11 kbd status", status, 8'h1D);
    chk("R11 kbd irq", {irq_kbd, irq_aux}, 2'b10);
    expect_ev(0, 8'hDF, "R6 outport full bit"); put(1, 8'hD0);
    put(1, 8'hAD); chk("R11 kbd off irq", irq_kbd, 1'b0);
    put(1, 8'hAE);
    @(negedge clk); kbd_pending = 0; aux_pending = 1; @(negedge clk);
    chk("R11 aux status", status, 8'h3D);
    chk("R11 aux irq", {irq_kbd, irq_aux}, 2'b01);
    expect_ev(0, 8'hFF, "R6 outport aux full"); put(1, 8'hD0);
    @(negedge clk); kbd_pending = 1; @(negedge clk);
    chk("R11 priority", {status, irq_kbd, irq_aux}, {8'h1D, 2'b10});
    put(1, 8'h60); put(0, 8'h00);
    chk("R11 irq masked", {irq_kbd, irq_aux}, 2'b00);
    @(negedge clk); kbd_pending = 0;
    @(negedge clk); chk("R11 aux masked", irq_aux, 1'b0);

    repeat (2) @(negedge clk);
    chk("R3 all events seen", ek.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule